// File: doc/BRIEF.md
# Capture/Reload Up-Down Timer

This block is a 16-bit timer/counter paired with one 16-bit hold register. The hold register serves either as a capture target or as a reload source. Four operating modes are decoded from a few control bits:

- **Capture**: free-running up-count, with snapshots taken on a trigger pin.
- **Reload**: up-count that reloads on overflow or on a trigger.
- **Up/down**: the trigger pin sets the count direction.
- **Baud**: a periodic reload produces a one-cycle baud tick for a serial engine.

Each count step comes from one of two sources. One is a single-cycle tick from a prescaler outside the block. The other is a falling edge on an external count pin.

Two raw pins are brought in through synchronisers: the count pin and the trigger/direction pin. An edge on either pin is recognised by comparing two successive synchronised samples. Software loads the counter and the hold register one byte at a time, over a shared write-data bus with per-byte strobes. It clears the two sticky flags with one-cycle clear pulses. The interrupt request is formed from the overflow flag and the external-event flag. In up/down mode the external-event flag is left out of the request, because there it only marks reload parity.

Top module: `cr_updown_timer`

## Requirements
- R1: While reset is asserted and after its release, count, hold_val, ovf_flag, ext_flag, irq and baud_tick are all zero until stimulus arrives.
- R2: When run_en is 0, the counter never steps.
  - With run_en=1 and ext_src_sel=0, the counter steps once per cycle in which tick_int is high.
  - With run_en=1 and ext_src_sel=1, tick_int is ignored and the counter steps once per falling edge of cnt_pin. The step takes effect on the third rising clock edge after the pin falls.
- R3: Capture mode is cap_sel=1 with rx_clk_sel=tx_clk_sel=0. In this mode each step adds one, and a step from FFFFh gives 0000h and sets ovf_flag.
- R4: In capture mode with trig_en=1, a falling edge of trig_pin does three things:
  - It copies the current count into hold_val.
  - It sets ext_flag.
  - It leaves the count unchanged.
- R5: Reload mode is cap_sel=0, updn_en=0 with both clock selects 0.
  - A step from FFFFh loads hold_val into the count and sets ovf_flag.
  - With trig_en=1, a falling edge of trig_pin loads hold_val into the count and sets ext_flag.
- R6: Up/down mode is cap_sel=0, updn_en=1 with both clock selects 0. The synchronised level of trig_pin gives the direction: 1 counts up, 0 counts down.
  - Counting up, a step from FFFFh loads hold_val.
  - Counting down, a step while count equals hold_val loads FFFFh. Otherwise a down step subtracts one, and 0000h wraps to FFFFh without a flag.
  - Every reload sets ovf_flag and inverts ext_flag.
  - A trig_pin falling edge has no other effect in this mode.
- R7: irq equals ovf_flag OR ext_flag, except that in up/down mode ext_flag is excluded.
- R8: Baud mode is selected whenever rx_clk_sel or tx_clk_sel is 1, regardless of cap_sel and updn_en.
  - A step from FFFFh loads hold_val and does not set ovf_flag. Instead, baud_tick is high for the one cycle that follows the reloading edge.
  - With trig_en=1, a trig_pin falling edge sets ext_flag.
- R9: cnt_wr_lo loads wr_data into count bits 7:0 at the next edge, and cnt_wr_hi loads wr_data into bits 15:8. In a cycle carrying either strobe, any count step or overflow is discarded.
- R10: hold_wr_lo and hold_wr_hi load wr_data into bits 7:0 and 15:8 of hold_val. In a cycle where a capture also occurs, the capture wins.
- R11: ovf_flag and ext_flag stay set until ovf_clr or ext_clr is pulsed. A set event in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Run enable for counting |
| ext_src_sel | input | 1 | 1: count falling edges of cnt_pin; 0: count tick_int |
| tick_int | input | 1 | Single-cycle internal time-base tick |
| cnt_pin | input | 1 | External count pin, asynchronous |
| trig_pin | input | 1 | External trigger / direction pin, asynchronous |
| trig_en | input | 1 | Enables trigger-pin falling-edge events |
| cap_sel | input | 1 | 1: capture mode, 0: reload modes |
| updn_en | input | 1 | Selects up/down reload when cap_sel=0 |
| rx_clk_sel | input | 1 | Receive clock select; forces baud mode |
| tx_clk_sel | input | 1 | Transmit clock select; forces baud mode |
| wr_data | input | 8 | Byte write data |
| cnt_wr_lo | input | 1 | Write strobe, counter low byte |
| cnt_wr_hi | input | 1 | Write strobe, counter high byte |
| hold_wr_lo | input | 1 | Write strobe, hold register low byte |
| hold_wr_hi | input | 1 | Write strobe, hold register high byte |
| ovf_clr | input | 1 | Clears ovf_flag |
| ext_clr | input | 1 | Clears ext_flag |
| count | output | 16 | Counter value |
| hold_val | output | 16 | Capture/reload register value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external-event flag |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-cycle pulse per baud-mode reload |

## Verification
The assertions assume the following about the block's inputs:
- tick_int is a one-cycle pulse.
- Mode bits are held steady around any step they are judged on.
- A counter byte write and a trigger do not both coincide with a wrap being checked.

The properties about overflow and down-compare reloads are therefore written with antecedents that exclude write strobes and flag clears. The stimulus changes mode bits only between checks, while no ticks are flowing. It holds each pin level for at least two cycles so that every edge passes the synchroniser cleanly. It issues simultaneous write/step and set/clear combinations only in the directed tests that target R9, R10 and R11.

// File: rtl/crt_pkg.sv
package crt_pkg;

  typedef enum logic [1:0] {
    MD_CAPTURE = 2'd0,
    MD_RELOAD  = 2'd1,
    MD_UPDOWN  = 2'd2,
    MD_BAUD    = 2'd3
  } crt_mode_e;

endpackage

// File: rtl/crt_rst_sync.sv
module crt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_ni = chain_q[STAGES-1];

endmodule

// File: rtl/crt_pin_sync.sv
module crt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       pin,
  output logic [1:0] tap
);

  // STAGES synchroniser flops plus one history flop; idle level is high
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '1;
    end else begin
      sh_q <= sh_d;
    end
  end

  // tap[0]: newest synchronised sample, tap[1]: the one before it
  assign tap = sh_q[STAGES:STAGES-1];

endmodule

// File: rtl/crt_count_core.sv
module crt_count_core
  import crt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              step,
  input  logic              dir_up,
  input  logic              trig_fall,
  input  logic              trig_en,
  input  logic              cap_sel,
  input  logic              updn_en,
  input  logic              rx_clk_sel,
  input  logic              tx_clk_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cnt_wr_lo,
  input  logic              cnt_wr_hi,
  input  logic              hold_wr_lo,
  input  logic              hold_wr_hi,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  hold_val,
  output crt_mode_e         mode,
  output logic              ovf_set,
  output logic              ext_set,
  output logic              ext_tog,
  output logic              baud_ev
);

  localparam int HI_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] ALL1 = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             at_top;
  logic             at_hold;
  logic             trig_hit;
  logic             cap_now;
  logic             cnt_wr_any;

  // mode decode: baud select overrides the capture/reload choice
  always_comb begin
    if (rx_clk_sel || tx_clk_sel) begin
      mode = MD_BAUD;
    end else if (cap_sel) begin
      mode = MD_CAPTURE;
    end else if (updn_en) begin
      mode = MD_UPDOWN;
    end else begin
      mode = MD_RELOAD;
    end
  end

  assign at_top     = (cnt_q == ALL1);
  assign at_hold    = (cnt_q == hold_q);
  assign trig_hit   = trig_fall & trig_en;
  assign cap_now    = trig_hit & (mode == MD_CAPTURE);
  assign cnt_wr_any = cnt_wr_lo | cnt_wr_hi;

  always_comb begin
    cnt_d   = cnt_q;
    hold_d  = hold_q;
    ovf_set = 1'b0;
    ext_set = 1'b0;
    ext_tog = 1'b0;
    baud_ev = 1'b0;

    // counting
    if (step) begin
      case (mode)
        MD_CAPTURE: begin
          cnt_d   = cnt_q + ONE;
          ovf_set = at_top;
        end
        MD_RELOAD: begin
          if (at_top) begin
            cnt_d   = hold_q;
            ovf_set = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        MD_UPDOWN: begin
          if (dir_up) begin
            if (at_top) begin
              cnt_d   = hold_q;
              ovf_set = 1'b1;
              ext_tog = 1'b1;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (at_hold) begin
              cnt_d   = ALL1;
              ovf_set = 1'b1;
              ext_tog = 1'b1;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        MD_BAUD: begin
          if (at_top) begin
            cnt_d   = hold_q;
            baud_ev = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: begin
          cnt_d = cnt_q;
        end
      endcase
    end

    // trigger-pin events
    if (trig_hit) begin
      case (mode)
        MD_CAPTURE: begin
          hold_d  = cnt_q;
          ext_set = 1'b1;
        end
        MD_RELOAD: begin
          cnt_d   = hold_q;
          ext_set = 1'b1;
        end
        MD_BAUD: begin
          ext_set = 1'b1;
        end
        default: begin
          ext_set = 1'b0;
        end
      endcase
    end

    // software hold writes lose to a capture in the same cycle
    if (!cap_now) begin
      if (hold_wr_lo) begin
        hold_d[BYTE_W-1:0] = wr_data;
      end
      if (hold_wr_hi) begin
        hold_d[CNT_W-1:BYTE_W] = wr_data[HI_W-1:0];
      end
    end

    // software counter writes discard the step of this cycle
    if (cnt_wr_any) begin
      cnt_d   = cnt_q;
      ovf_set = 1'b0;
      ext_tog = 1'b0;
      baud_ev = 1'b0;
      if (cnt_wr_lo) begin
        cnt_d[BYTE_W-1:0] = wr_data;
      end
      if (cnt_wr_hi) begin
        cnt_d[CNT_W-1:BYTE_W] = wr_data[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign count    = cnt_q;
  assign hold_val = hold_q;

endmodule

// File: rtl/crt_flags.sv
module crt_flags
  import crt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  crt_mode_e mode,
  input  logic      ovf_set,
  input  logic      ext_set,
  input  logic      ext_tog,
  input  logic      baud_ev,
  input  logic      ovf_clr,
  input  logic      ext_clr,
  output logic      ovf_flag,
  output logic      ext_flag,
  output logic      baud_tick,
  output logic      irq
);

  logic ovf_q, ovf_d;
  logic ext_q, ext_d;
  logic bt_q, bt_d;
  logic ext_base;

  always_comb begin
    ovf_d    = (ovf_clr ? 1'b0 : ovf_q) | ovf_set;
    ext_base = (ext_clr ? 1'b0 : ext_q) | ext_set;
    ext_d    = ext_base ^ ext_tog;
    bt_d     = baud_ev;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
      bt_q  <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      ext_q <= ext_d;
      bt_q  <= bt_d;
    end
  end

  assign ovf_flag  = ovf_q;
  assign ext_flag  = ext_q;
  assign baud_tick = bt_q;
  assign irq       = ovf_q | (ext_q & (mode != MD_UPDOWN));

endmodule

// File: rtl/cr_updown_timer.sv
module cr_updown_timer
  import crt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              ext_src_sel,
  input  logic              tick_int,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              trig_en,
  input  logic              cap_sel,
  input  logic              updn_en,
  input  logic              rx_clk_sel,
  input  logic              tx_clk_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cnt_wr_lo,
  input  logic              cnt_wr_hi,
  input  logic              hold_wr_lo,
  input  logic              hold_wr_hi,
  input  logic              ovf_clr,
  input  logic              ext_clr,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  hold_val,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              irq,
  output logic              baud_tick
);

  localparam int NPIN     = 2;
  localparam int PIN_CNT  = 0;
  localparam int PIN_TRIG = 1;

  logic            rst_ni;
  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_fall;
  logic            dir_up;
  logic            step;
  logic            trig_fall;
  crt_mode_e       mode;
  logic            ovf_set;
  logic            ext_set;
  logic            ext_tog;
  logic            baud_ev;

  crt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  assign pin_raw = {trig_pin, cnt_pin};

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [1:0] tap;
    crt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_ni (rst_ni),
      .pin    (pin_raw[i]),
      .tap    (tap)
    );
    assign pin_fall[i] = tap[1] & ~tap[0];
  end

  assign dir_up    = g_pin[PIN_TRIG].tap[0];
  assign trig_fall = pin_fall[PIN_TRIG];
  assign step      = run_en & (ext_src_sel ? pin_fall[PIN_CNT] : tick_int);

  crt_count_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .step       (step),
    .dir_up     (dir_up),
    .trig_fall  (trig_fall),
    .trig_en    (trig_en),
    .cap_sel    (cap_sel),
    .updn_en    (updn_en),
    .rx_clk_sel (rx_clk_sel),
    .tx_clk_sel (tx_clk_sel),
    .wr_data    (wr_data),
    .cnt_wr_lo  (cnt_wr_lo),
    .cnt_wr_hi  (cnt_wr_hi),
    .hold_wr_lo (hold_wr_lo),
    .hold_wr_hi (hold_wr_hi),
    .count      (count),
    .hold_val   (hold_val),
    .mode       (mode),
    .ovf_set    (ovf_set),
    .ext_set    (ext_set),
    .ext_tog    (ext_tog),
    .baud_ev    (baud_ev)
  );

  crt_flags u_flags (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .mode      (mode),
    .ovf_set   (ovf_set),
    .ext_set   (ext_set),
    .ext_tog   (ext_tog),
    .baud_ev   (baud_ev),
    .ovf_clr   (ovf_clr),
    .ext_clr   (ext_clr),
    .ovf_flag  (ovf_flag),
    .ext_flag  (ext_flag),
    .baud_tick (baud_tick),
    .irq       (irq)
  );

endmodule

// File: rtl/crt_checker.sv
module crt_checker
  import crt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input crt_mode_e         mode,
  input logic              step,
  input logic              dir_up,
  input logic              cnt_wr_lo,
  input logic              cnt_wr_hi,
  input logic              ovf_clr,
  input logic              ext_clr,
  input logic [BYTE_W-1:0] wr_data,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  hold_val,
  input logic              ovf_flag,
  input logic              ext_flag,
  input logic              irq,
  input logic              baud_tick
);

  a_r3_capture_wrap: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MD_CAPTURE && step && count == '1 && !cnt_wr_lo && !cnt_wr_hi)
      |=> (ovf_flag && count == '0));

  a_r6_down_hit_reload: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MD_UPDOWN && step && !dir_up && count == hold_val &&
     !cnt_wr_lo && !cnt_wr_hi && !ext_clr)
      |=> (count == '1 && ovf_flag && ext_flag != $past(ext_flag)));

  a_r8_baud_no_overflow: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ovf_flag) |-> ($past(mode) != MD_BAUD));

  a_r8_tick_only_in_baud: assert property (@(posedge clk) disable iff (!rst_ni)
    baud_tick |-> ($past(mode) == MD_BAUD));

  a_r9_low_byte_write: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_wr_lo |=> (count[BYTE_W-1:0] == $past(wr_data)));

  a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r11_external_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (ext_flag && !ext_clr && mode != MD_UPDOWN) |=> ext_flag);

  a_r7_irq_from_overflow: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_flag |-> irq);

  a_r7_updown_masks_ext: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MD_UPDOWN && !ovf_flag) |-> !irq);

endmodule

bind cr_updown_timer crt_checker #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .mode      (mode),
  .step      (step),
  .dir_up    (dir_up),
  .cnt_wr_lo (cnt_wr_lo),
  .cnt_wr_hi (cnt_wr_hi),
  .ovf_clr   (ovf_clr),
  .ext_clr   (ext_clr),
  .wr_data   (wr_data),
  .count     (count),
  .hold_val  (hold_val),
  .ovf_flag  (ovf_flag),
  .ext_flag  (ext_flag),
  .irq       (irq),
  .baud_tick (baud_tick)
);

// File: tb/tb_cr_updown_timer.sv
module tb_cr_updown_timer;

  logic        clk;
  logic        rst_n;
  logic        run_en, ext_src_sel, tick_int, cnt_pin, trig_pin, trig_en;
  logic        cap_sel, updn_en, rx_clk_sel, tx_clk_sel;
  logic [7:0]  wr_data;
  logic        cnt_wr_lo, cnt_wr_hi, hold_wr_lo, hold_wr_hi, ovf_clr, ext_clr;
  logic [15:0] count, hold_val;
  logic        ovf_flag, ext_flag, irq, baud_tick;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  cr_updown_timer dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ext_src_sel(ext_src_sel),
    .tick_int(tick_int), .cnt_pin(cnt_pin), .trig_pin(trig_pin), .trig_en(trig_en),
    .cap_sel(cap_sel), .updn_en(updn_en), .rx_clk_sel(rx_clk_sel), .tx_clk_sel(tx_clk_sel),
    .wr_data(wr_data), .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi),
    .hold_wr_lo(hold_wr_lo), .hold_wr_hi(hold_wr_hi), .ovf_clr(ovf_clr), .ext_clr(ext_clr),
    .count(count), .hold_val(hold_val), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .irq(irq), .baud_tick(baud_tick)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // mode code: 0 capture, 1 reload, 2 up/down, 3 baud
  typedef struct packed {
    logic [1:0]  md;
    logic        dir;
    logic [15:0] start;
    logic [15:0] rld;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
    logic        exp_ext;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 16'hFFFE, 16'h1234, 8'd3, 16'h0001, 1'b1, 1'b0},
    '{2'd0, 1'b1, 16'h0010, 16'h1234, 8'd5, 16'h0015, 1'b0, 1'b0},
    '{2'd1, 1'b1, 16'hFFFE, 16'h8000, 8'd2, 16'h8000, 1'b1, 1'b0},
    '{2'd1, 1'b1, 16'hFFFF, 16'h00F0, 8'd4, 16'h00F3, 1'b1, 1'b0},
    '{2'd2, 1'b1, 16'hFFFF, 16'h0100, 8'd1, 16'h0100, 1'b1, 1'b1},
    '{2'd2, 1'b0, 16'h0102, 16'h0100, 8'd3, 16'hFFFF, 1'b1, 1'b1},
    '{2'd2, 1'b0, 16'hFFFF, 16'hFFFF, 8'd2, 16'hFFFF, 1'b1, 1'b0},
    '{2'd3, 1'b1, 16'hFFFE, 16'hABCD, 8'd2, 16'hABCD, 1'b0, 1'b0},
    '{2'd2, 1'b0, 16'h0005, 16'h0100, 8'd5, 16'h0000, 1'b0, 1'b0},
    '{2'd2, 1'b0, 16'h0000, 16'h0100, 8'd1, 16'hFFFF, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks are entered and left at a falling clock edge
  task automatic wr_count(input logic [15:0] v);
    wr_data = v[7:0];  cnt_wr_lo = 1'b1; @(negedge clk); cnt_wr_lo = 1'b0;
    wr_data = v[15:8]; cnt_wr_hi = 1'b1; @(negedge clk); cnt_wr_hi = 1'b0;
  endtask

  task automatic wr_hold(input logic [15:0] v);
    wr_data = v[7:0];  hold_wr_lo = 1'b1; @(negedge clk); hold_wr_lo = 1'b0;
    wr_data = v[15:8]; hold_wr_hi = 1'b1; @(negedge clk); hold_wr_hi = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] md, input logic dir);
    cap_sel    = (md == 2'd0) || (md == 2'd3);
    updn_en    = (md == 2'd2);
    tx_clk_sel = (md == 2'd3);
    trig_pin   = dir;
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_int = 1'b1; @(negedge clk);
    end
    tick_int = 1'b0;
  endtask

  task automatic clear_flags();
    ovf_clr = 1'b1; ext_clr = 1'b1; @(negedge clk);
    ovf_clr = 1'b0; ext_clr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; ext_src_sel = 1'b0; tick_int = 1'b0;
    cnt_pin = 1'b1; trig_pin = 1'b1; trig_en = 1'b0; cap_sel = 1'b0;
    updn_en = 1'b0; rx_clk_sel = 1'b0; tx_clk_sel = 1'b0; wr_data = 8'h00;
    cnt_wr_lo = 1'b0; cnt_wr_hi = 1'b0; hold_wr_lo = 1'b0; hold_wr_hi = 1'b0;
    ovf_clr = 1'b0; ext_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 count", count, 16'h0000);
    chk("R1 hold_val", hold_val, 16'h0000);
    chk("R1 ovf_flag", {15'd0, ovf_flag}, 16'd0);
    chk("R1 ext_flag", {15'd0, ext_flag}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 baud_tick", {15'd0, baud_tick}, 16'd0);

    run_en = 1'b1;

    // table of mode vectors (R3, R5, R6, R8)
    for (int v = 0; v < NV; v++) begin
      string tag;
      case (VECS[v].md)
        2'd0:    tag = "R3";
        2'd1:    tag = "R5";
        2'd2:    tag = "R6";
        default: tag = "R8";
      endcase
      set_mode(VECS[v].md, VECS[v].dir);
      clear_flags();
      wr_hold(VECS[v].rld);
      wr_count(VECS[v].start);
      ticks(int'(VECS[v].n));
      chk($sformatf("%s vec%0d count", tag, v), count, VECS[v].exp_cnt);
      chk($sformatf("%s vec%0d ovf", tag, v), {15'd0, ovf_flag}, {15'd0, VECS[v].exp_ovf});
      chk($sformatf("%s vec%0d ext", tag, v), {15'd0, ext_flag}, {15'd0, VECS[v].exp_ext});
    end

    // R2 run enable and count source
    set_mode(2'd0, 1'b1);
    clear_flags();
    wr_count(16'h0100);
    run_en = 1'b0;
    ticks(3);
    chk("R2 run_en=0 holds", count, 16'h0100);
    run_en = 1'b1;
    ext_src_sel = 1'b1;
    ticks(2);
    chk("R2 tick ignored on pin source", count, 16'h0100);
    for (int e = 0; e < 3; e++) begin
      cnt_pin = 1'b0; repeat (2) @(negedge clk);
      cnt_pin = 1'b1; repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk("R2 pin falling edges", count, 16'h0103);
    ext_src_sel = 1'b0;

    // R4 capture on trigger
    clear_flags();
    wr_count(16'h4321);
    trig_en = 1'b1;
    trig_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 hold captured", hold_val, 16'h4321);
    chk("R4 count unchanged", count, 16'h4321);
    chk("R4 ext_flag", {15'd0, ext_flag}, 16'd1);
    chk("R7 irq from ext", {15'd0, irq}, 16'd1);
    trig_pin = 1'b1; repeat (3) @(negedge clk);

    // R5 trigger reload
    trig_en = 1'b0;
    set_mode(2'd1, 1'b1);
    clear_flags();
    wr_hold(16'h0777);
    wr_count(16'h1000);
    trig_en = 1'b1;
    trig_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 trigger reload count", count, 16'h0777);
    chk("R5 trigger ext_flag", {15'd0, ext_flag}, 16'd1);
    trig_pin = 1'b1; repeat (3) @(negedge clk);

    // R6 trigger has no reload effect in up/down, R7 masking
    set_mode(2'd2, 1'b1);
    clear_flags();
    wr_hold(16'h0200);
    wr_count(16'h0050);
    trig_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 trigger ignored ext", {15'd0, ext_flag}, 16'd0);
    chk("R6 trigger ignored count", count, 16'h0050);
    wr_count(16'h0200);
    ticks(1);
    chk("R6 down hit count", count, 16'hFFFF);
    chk("R6 down hit ext", {15'd0, ext_flag}, 16'd1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R7 ext masked in up/down", {15'd0, irq}, 16'd0);
    trig_en = 1'b0;
    updn_en = 1'b0;
    @(negedge clk);
    chk("R7 ext unmasked in reload", {15'd0, irq}, 16'd1);
    clear_flags();
    trig_pin = 1'b1; repeat (3) @(negedge clk);

    // R8 baud tick and external flag
    set_mode(2'd3, 1'b1);
    clear_flags();
    wr_hold(16'h1234);
    wr_count(16'hFFFF);
    tick_int = 1'b1; @(negedge clk); tick_int = 1'b0;
    chk("R8 baud reload count", count, 16'h1234);
    chk("R8 baud_tick high", {15'd0, baud_tick}, 16'd1);
    chk("R8 no ovf in baud", {15'd0, ovf_flag}, 16'd0);
    @(negedge clk);
    chk("R8 baud_tick one cycle", {15'd0, baud_tick}, 16'd0);
    trig_en = 1'b1;
    trig_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 baud trigger ext", {15'd0, ext_flag}, 16'd1);
    trig_en = 1'b0;
    trig_pin = 1'b1; repeat (3) @(negedge clk);

    // R9 write beats a step in the same cycle
    set_mode(2'd0, 1'b1);
    clear_flags();
    wr_count(16'h0010);
    tick_int = 1'b1; cnt_wr_lo = 1'b1; wr_data = 8'h55;
    @(negedge clk);
    tick_int = 1'b0; cnt_wr_lo = 1'b0;
    chk("R9 write wins over tick", count, 16'h0055);

    // R10 capture beats a hold write in the same cycle
    wr_count(16'h2468);
    trig_en = 1'b1;
    trig_pin = 1'b0;
    repeat (2) @(negedge clk);
    hold_wr_lo = 1'b1; wr_data = 8'hAA;
    @(negedge clk);
    hold_wr_lo = 1'b0;
    chk("R10 capture wins over write", hold_val, 16'h2468);
    trig_en = 1'b0;
    trig_pin = 1'b1; repeat (3) @(negedge clk);
    wr_hold(16'hBEEF);
    chk("R10 hold write", hold_val, 16'hBEEF);

    // R11 set beats clear, flags sticky
    set_mode(2'd1, 1'b1);
    clear_flags();
    wr_hold(16'h0000);
    wr_count(16'hFFFF);
    tick_int = 1'b1; ovf_clr = 1'b1;
    @(negedge clk);
    tick_int = 1'b0; ovf_clr = 1'b0;
    chk("R11 set beats clear", {15'd0, ovf_flag}, 16'd1);
    repeat (2) @(negedge clk);
    chk("R11 flag sticky", {15'd0, ovf_flag}, 16'd1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R11 clear", {15'd0, ovf_flag}, 16'd0);

    done = 1;
    summary();
    $finish;
  end

endmodule